// File: doc/BRIEF.md
# Comparator Result Conditioner

This block takes the one-bit decision of an analog voltage comparator, which arrives with no relation to the system clock, and turns it into clean signals for the rest of a microcontroller. The raw decision first passes through a synchronizer. An optional majority-free noise filter then samples it at one of three rates taken from the system clock, and the filter accepts a new level only when a run of consecutive samples agrees on it. A selectable edge on the conditioned level raises a one-clock interrupt request. The same level drives an external pin, which can be inverted and which is held low unless the pin is enabled.

All control arrives as static register-style input fields: a block enable, a filter-rate select, an edge select, pin polarity, pin enable, interrupt enable and a stabilization length. While the block is disabled its filter, prescaler, edge history and stabilization counter are held cleared, and both the pin and the interrupt stay low. After the block is enabled, edges raise no interrupt until the programmed stabilization time has passed. This covers the settling time of the analog part.

Top module: `vcmp_cond`

## Requirements
- R1: The raw input passes through two synchronizer flops. With filter select 00 (bypass), `cmp_level` equals the raw input as it was two clocks earlier.
- R2: Filter select picks the sampling rate. 01 samples on every clock, 10 samples on the clock where the low three bits of a free-running 5-bit count are all ones (once per 8 clocks), and 11 samples on the clock where the whole count is 31 (once per 32 clocks). The count restarts from 0 on the first enabled clock.
- R3: With filtering on, `cmp_level` takes a new value only on a sampling clock on which that sample and the two samples before it all show that value. Otherwise it holds, so pulses shorter than three sample periods are ignored.
- R4: Edge select 00 reacts to rising edges of `cmp_level`, 01 to falling edges, and 10 or 11 to both. An edge is a difference between `cmp_level` and its value one clock earlier.
- R5: A selected edge, with `irq_en` = 1, raises `irq_pulse` for exactly one clock, in the clock after the edge. With `irq_en` = 0, no pulse is raised.
- R6: `pin_out` is one clock behind `cmp_level`: it is `cmp_level` XOR `pin_inv` when `pin_en` = 1 and 0 when `pin_en` = 0.
- R7: While `cmp_en` = 0, `pin_out` and `irq_pulse` are 0 and the filter level, filter sample history, prescaler, edge history and stabilization counter are held at 0.
- R8: After `cmp_en` rises, no interrupt is raised until `stab_len` enabled clocks have elapsed. The first enabled clock on which an edge may raise an interrupt is the clock numbered `stab_len`, counting from 0.
- R9: During reset `cmp_level`, `pin_out` and `irq_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator decision |
| cmp_en | input | 1 | Block enable |
| flt_sel | input | 2 | Filter mode: 00 bypass, 01 every clock, 10 every 8, 11 every 32 |
| edg_sel | input | 2 | Edge mode: 00 rising, 01 falling, 1x both |
| pin_inv | input | 1 | Invert the level driven on the pin |
| pin_en | input | 1 | Drive the level onto the pin |
| irq_en | input | 1 | Allow edges to raise interrupts |
| stab_len | input | STAB_W | Stabilization clocks after enable |
| cmp_level | output | 1 | Conditioned comparator level |
| pin_out | output | 1 | External pin drive |
| irq_pulse | output | 1 | One-clock interrupt request |

## Verification
The hardest behaviour to reach from the ports is the slow filter at the moment it accepts or refuses a level. The outcome depends on where three samples, 32 clocks apart, fall against the raw pulses, and that alignment is fixed by the prescaler phase, which starts at the enable. The stimulus therefore mixes long holds with glitches of several lengths in each filter mode, and a per-clock model keeps track of the sample phase to judge every cycle. A second hard case is an edge that arrives during the stabilization window. It is produced by enabling the block with a nonzero length while the input toggles quickly, so that edges arrive both inside and after the window.

// File: rtl/vcmp_cond_pkg.sv
package vcmp_cond_pkg;

   typedef enum logic [1:0] {
      FLT_OFF      = 2'b00,
      FLT_EVERY    = 2'b01,
      FLT_DIV_MID  = 2'b10,
      FLT_DIV_SLOW = 2'b11
   } flt_mode_e;

   // Edge selection: upper bit set means both directions.
   function automatic logic edge_hit(input logic [1:0] mode,
                                     input logic cur,
                                     input logic prev);
      if (mode[1])
         return cur ^ prev;
      else if (mode[0])
         return prev & ~cur;
      else
         return cur & ~prev;
   endfunction

endpackage

// File: rtl/vcmp_sync.sv
module vcmp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("vcmp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vcmp_prescale.sv
module vcmp_prescale
   import vcmp_cond_pkg::*;
#(
   parameter int DIV_MID  = 8,
   parameter int DIV_SLOW = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  flt_mode_e mode,
   output logic      strobe
);
   localparam int CW    = $clog2(DIV_SLOW);
   localparam int MID_W = $clog2(DIV_MID);

   generate
      if (DIV_MID < 2 || (1 << MID_W) != DIV_MID) begin : g_bad_mid
         $error("vcmp_prescale: DIV_MID must be a power of two >= 2");
      end
      if ((1 << CW) != DIV_SLOW || DIV_SLOW <= DIV_MID) begin : g_bad_slow
         $error("vcmp_prescale: DIV_SLOW must be a power of two above DIV_MID");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   always_comb begin
      strobe = 1'b0;
      if (en) begin
         unique case (mode)
            FLT_OFF:      strobe = 1'b0;
            FLT_EVERY:    strobe = 1'b1;
            FLT_DIV_MID:  strobe = &cnt[MID_W-1:0];
            FLT_DIV_SLOW: strobe = &cnt;
            default:      strobe = 1'b0;
         endcase
      end
   end

   AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (en && strobe && (mode == FLT_DIV_MID || mode == FLT_DIV_SLOW))
      |=> (!strobe || mode == FLT_EVERY)); // R2
endmodule

// File: rtl/vcmp_filter.sv
module vcmp_filter #(
   parameter int AGREE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic strobe,
   input  logic smp,
   output logic lvl
);
   generate
      if (AGREE < 2) begin : g_bad
         $error("vcmp_filter: AGREE must be at least 2");
      end
   endgenerate

   localparam int HW = AGREE - 1;

   logic [HW-1:0]    hist;
   logic [HW-1:0]    hist_nx;
   logic [AGREE-1:0] window;

   assign window = {hist, smp};

   generate
      if (HW == 1) begin : g_short
         assign hist_nx = smp;
      end else begin : g_long
         assign hist_nx = {hist[HW-2:0], smp};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         lvl  <= 1'b0;
      end else if (!en) begin
         hist <= '0;
         lvl  <= 1'b0;
      end else if (strobe) begin
         hist <= hist_nx;
         if (&window)
            lvl <= 1'b1;
         else if (~|window)
            lvl <= 1'b0;
      end
   end

   AST_FILT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !strobe) |=> $stable(lvl)); // R3
   AST_FILT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && strobe && (smp != hist[0])) |=> $stable(lvl)); // R3
endmodule

// File: rtl/vcmp_edge.sv
module vcmp_edge
   import vcmp_cond_pkg::*;
#(
   parameter int STAB_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              lvl,
   input  logic [1:0]        mode,
   input  logic              irq_en,
   input  logic [STAB_W-1:0] stab_len,
   output logic              irq
);
   logic              prev;
   logic [STAB_W-1:0] stab_cnt;
   logic              ready;
   logic              hit;

   assign ready = (stab_cnt >= stab_len);
   assign hit   = edge_hit(mode, lvl, prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= 1'b0;
         stab_cnt <= '0;
         irq      <= 1'b0;
      end else if (!en) begin
         prev     <= 1'b0;
         stab_cnt <= '0;
         irq      <= 1'b0;
      end else begin
         prev <= lvl;
         if (!ready)
            stab_cnt <= stab_cnt + 1'b1;
         irq <= irq_en & ready & hit;
      end
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(en && irq_en)); // R5
   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq); // R7
endmodule

// File: rtl/vcmp_cond.sv
module vcmp_cond
   import vcmp_cond_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int AGREE       = 3,
   parameter int DIV_MID     = 8,
   parameter int DIV_SLOW    = 32,
   parameter int STAB_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw,
   input  logic              cmp_en,
   input  logic [1:0]        flt_sel,
   input  logic [1:0]        edg_sel,
   input  logic              pin_inv,
   input  logic              pin_en,
   input  logic              irq_en,
   input  logic [STAB_W-1:0] stab_len,
   output logic              cmp_level,
   output logic              pin_out,
   output logic              irq_pulse
);
   generate
      if (STAB_W < 1 || STAB_W > 16) begin : g_bad_stab
         $error("vcmp_cond: STAB_W must be 1..16");
      end
   endgenerate

   flt_mode_e fmode;
   logic      sync_q;
   logic      strobe;
   logic      filt_q;
   logic      lvl;

   assign fmode = flt_mode_e'(flt_sel);

   vcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(sync_q)
   );

   vcmp_prescale #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(cmp_en), .mode(fmode), .strobe(strobe)
   );

   vcmp_filter #(.AGREE(AGREE)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(cmp_en), .strobe(strobe),
      .smp(sync_q), .lvl(filt_q)
   );

   assign lvl = (fmode == FLT_OFF) ? sync_q : filt_q;

   vcmp_edge #(.STAB_W(STAB_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .en(cmp_en), .lvl(lvl), .mode(edg_sel),
      .irq_en(irq_en), .stab_len(stab_len), .irq(irq_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pin_out <= 1'b0;
      else
         pin_out <= cmp_en & pin_en & (lvl ^ pin_inv);
   end

   assign cmp_level = lvl;

   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_en && pin_en) |=> !pin_out); // R6
   AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> !pin_out); // R7
endmodule

// File: tb/vcmp_cond_test.sv
module vcmp_cond_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0;
   logic       cmp_en = 1'b0;
   logic [1:0] flt_sel = 2'b00;
   logic [1:0] edg_sel = 2'b00;
   logic       pin_inv = 1'b0;
   logic       pin_en = 1'b0;
   logic       irq_en = 1'b0;
   logic [7:0] stab_len = 8'd0;
   logic       cmp_level, pin_out, irq_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   string tag_lvl = "R1";
   string tag_irq = "R4";
   string tag_pin = "R6";

   always #10 clk = ~clk;

   vcmp_cond uut (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cmp_en(cmp_en),
      .flt_sel(flt_sel), .edg_sel(edg_sel), .pin_inv(pin_inv),
      .pin_en(pin_en), .irq_en(irq_en), .stab_len(stab_len),
      .cmp_level(cmp_level), .pin_out(pin_out), .irq_pulse(irq_pulse)
   );

   // Behavioural reference
   int m_s1, m_s2, m_cnt, m_old1, m_old2, m_f, m_prev, m_stab, m_irq, m_pin;

   function automatic int model_level();
      return (flt_sel == 2'b00) ? m_s2 : m_f;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_cnt = 0; m_old1 = 0; m_old2 = 0;
         m_f = 0; m_prev = 0; m_stab = 0; m_irq = 0; m_pin = 0;
      end else begin
         int lv, smp_now, hit, take;
         lv = model_level();
         take = 0;
         if (cmp_en) begin
            case (flt_sel)
               2'b01: take = 1;
               2'b10: take = ((m_cnt % 8) == 7);
               2'b11: take = (m_cnt == 31);
               default: take = 0;
            endcase
         end
         if (edg_sel[1]) hit = (lv != m_prev);
         else if (edg_sel[0]) hit = (m_prev == 1 && lv == 0);
         else hit = (m_prev == 0 && lv == 1);
         m_pin = (cmp_en && pin_en) ? (lv ^ int'(pin_inv)) : 0;
         if (!cmp_en) begin
            m_irq = 0; m_cnt = 0; m_old1 = 0; m_old2 = 0;
            m_f = 0; m_prev = 0; m_stab = 0;
         end else begin
            m_irq = (irq_en && m_stab >= int'(stab_len) && hit) ? 1 : 0;
            m_cnt = (m_cnt + 1) % 32;
            if (take) begin
               smp_now = m_s2;
               if (m_old1 == smp_now && m_old2 == smp_now) m_f = smp_now;
               m_old2 = m_old1;
               m_old1 = smp_now;
            end
            m_prev = lv;
            if (m_stab < int'(stab_len)) m_stab = m_stab + 1;
         end
         m_s2 = m_s1;
         m_s1 = int'(cmp_raw);
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_lvl, "cmp_level", int'(cmp_level), model_level());
         check(tag_irq, "irq_pulse", int'(irq_pulse), m_irq);
         check(tag_pin, "pin_out",   int'(pin_out),   m_pin);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic hold(input logic v, input int n);
      cmp_raw = v;
      step(n);
   endtask

   task automatic toggles(input int n, input int period);
      for (int i = 0; i < n; i++) hold(~cmp_raw, period);
   endtask

   initial begin
      step(2);
      @(negedge clk);
      check("R9", "reset cmp_level", int'(cmp_level), 0);
      check("R9", "reset pin_out",   int'(pin_out),   0);
      check("R9", "reset irq_pulse", int'(irq_pulse), 0);
      rst_n = 1'b1;
      step(1);

      // Bypass, rising edges
      tag_lvl = "R1"; tag_irq = "R4"; tag_pin = "R6";
      cmp_en = 1; irq_en = 1; pin_en = 1; stab_len = 0; edg_sel = 2'b00;
      step(3);
      toggles(6, 4);
      toggles(6, 1);
      edg_sel = 2'b01; toggles(8, 3);
      edg_sel = 2'b10; toggles(8, 2);
      edg_sel = 2'b11; toggles(6, 5);
      pin_inv = 1; toggles(6, 3);
      tag_irq = "R5"; irq_en = 0; toggles(6, 3);
      irq_en = 1;
      pin_en = 0; toggles(6, 3);
      pin_en = 1; pin_inv = 0;

      // Filter every clock
      tag_lvl = "R3"; tag_irq = "R4";
      flt_sel = 2'b01; edg_sel = 2'b10;
      hold(0, 6);
      for (int w = 1; w <= 5; w++) begin hold(1, w); hold(0, 6); end
      for (int w = 1; w <= 5; w++) begin hold(0, w); hold(1, 6); end

      // Filter once per 8 and once per 32
      tag_lvl = "R2";
      flt_sel = 2'b10;
      hold(0, 40);
      for (int w = 3; w <= 27; w += 4) begin hold(1, w); hold(0, 30); end
      hold(1, 40);
      flt_sel = 2'b11;
      hold(0, 120);
      for (int w = 20; w <= 100; w += 20) begin hold(1, w); hold(0, 110); end
      hold(1, 120);
      toggles(10, 7);

      // Disable with activity
      tag_lvl = "R7"; tag_irq = "R7"; tag_pin = "R7";
      cmp_en = 0; flt_sel = 2'b01;
      toggles(10, 4);

      // Stabilization window in bypass and filtered
      tag_lvl = "R1"; tag_irq = "R8"; tag_pin = "R6";
      flt_sel = 2'b00; edg_sel = 2'b10; stab_len = 8'd20;
      cmp_en = 1;
      toggles(20, 3);
      cmp_en = 0; step(3);
      tag_lvl = "R3";
      flt_sel = 2'b01; stab_len = 8'd7; cmp_en = 1;
      toggles(12, 4);
      cmp_en = 0; step(2);
      stab_len = 8'd0; flt_sel = 2'b00; cmp_raw = 1; cmp_en = 1;
      toggles(4, 3);
      step(4);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule